// File: doc/BRIEF.md
# Hall Sensor Position Detector

This block watches three rotor-position sensor inputs that have already been synchronized and filtered. It decides when the rotor has reached a valid position. When it has, it emits a single-cycle write-timing strobe to a downstream controller. Each detection also latches an interrupt flag, which stays set until a clear strobe arrives. The interrupt line is driven from that flag through an enable bit.

There are two modes of detection:

- **Edge mode.** Each input has its own enable bit. A 2-bit field chooses whether rising edges, falling edges, both, or none count.
- **Compare mode.** Any level change on any input starts a comparison. The comparison uses the new 3-bit input pattern and a programmed expected pattern. The strobe fires only when the two are equal.

The inputs are registered once inside the block. Edges are found by comparing that registered sample with the previous one.

Top module: `hall_pos_detect`

## Requirements
- R1: With `cfg_cmp_mode`=0 and `cfg_edge_sel`=2'b10, a 0-to-1 transition on an enabled input produces a strobe. A 1-to-0 transition on the same input does not.
- R2: With `cfg_cmp_mode`=0, `cfg_edge_sel`=2'b01 makes only 1-to-0 transitions count, and 2'b11 makes both directions count.
- R3: With `cfg_cmp_mode`=0 and `cfg_edge_sel`=2'b00, no input activity produces a strobe.
- R4: In edge mode, transitions on an input whose bit in `cfg_in_en` is 0 have no effect on `wr_pulse`. Bit i of `cfg_in_en` enables `sense_in[i]`.
- R5: With `cfg_cmp_mode`=1, a change on any input produces a strobe exactly when the new sample equals `cfg_expect`. `cfg_in_en` and `cfg_edge_sel` are ignored in this mode.
- R6: In compare mode, an input pattern that stays unchanged produces no further strobe, even while it equals `cfg_expect`.
- R7: Each detection gives a `wr_pulse` exactly one cycle wide. Changes on several inputs in the same cycle give one strobe.
- R8: Each strobe sets `irq_pend`, and `irq_pend` stays set until `irq_clr` is sampled high. When a clear and a detection fall in the same cycle, `irq_pend` remains set.
- R9: `irq` is high only while both `irq_pend` and `cfg_irq_en` are high.
- R10: A synchronous active-high `rst` clears `wr_pulse`, `irq_pend` and the input history. No strobe follows reset, even when the inputs are high at release.
- R11: When a qualifying input value is set up before clock edge k, `wr_pulse` is high during the cycle after edge k+1, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cmp_mode | input | 1 | 0: edge mode, 1: compare mode |
| cfg_in_en | input | 3 | Per-input enable, used in edge mode |
| cfg_edge_sel | input | 2 | 10 rising, 01 falling, 11 both, 00 none |
| cfg_expect | input | 3 | Expected position pattern for compare mode |
| cfg_irq_en | input | 1 | Gates the interrupt flag onto `irq` |
| sense_in | input | 3 | Sensor inputs |
| irq_clr | input | 1 | Clears `irq_pend` |
| wr_pulse | output | 1 | One-cycle write-timing strobe |
| irq_pend | output | 1 | Latched position-detect flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a clear that lands in exactly the cycle where a new detection is registered. To reach it, the bench first makes the input change. It then waits one edge, raises `irq_clr` so that it lines up with the strobe's edge, and checks that the flag survives.

A second hard case is a reset released while the inputs are already high. The bench holds all inputs high across reset with every edge enabled. This exposes any false edge taken against the cleared input history.

Compare mode is driven with:

- mismatching changes;
- a steady matching pattern;
- a multi-bit change onto the expected value.

// File: rtl/hall_pos_detect.sv
module hall_pos_detect #(
  parameter int NSENSE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cmp_mode,
  input  logic [NSENSE-1:0] cfg_in_en,
  input  logic [1:0]        cfg_edge_sel,
  input  logic [NSENSE-1:0] cfg_expect,
  input  logic              cfg_irq_en,
  input  logic [NSENSE-1:0] sense_in,
  input  logic              irq_clr,
  output logic              wr_pulse,
  output logic              irq_pend,
  output logic              irq
);

  logic [NSENSE-1:0] samp_q, prev_q;
  logic              samp_ok_q, prev_ok_q;

  wire [NSENSE-1:0] rise = samp_q & ~prev_q;
  wire [NSENSE-1:0] fall = ~samp_q & prev_q;
  wire [NSENSE-1:0] qual = cfg_in_en & ((rise & {NSENSE{cfg_edge_sel[1]}}) |
                                        (fall & {NSENSE{cfg_edge_sel[0]}}));
  wire edge_hit = |qual;
  wire cmp_hit  = (samp_q != prev_q) && (samp_q == cfg_expect);
  wire det      = prev_ok_q && (cfg_cmp_mode ? cmp_hit : edge_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q    <= '0;
      prev_q    <= '0;
      samp_ok_q <= 1'b0;
      prev_ok_q <= 1'b0;
      wr_pulse  <= 1'b0;
      irq_pend  <= 1'b0;
    end else begin
      samp_q    <= sense_in;
      prev_q    <= samp_q;
      samp_ok_q <= 1'b1;
      prev_ok_q <= samp_ok_q;
      wr_pulse  <= det;
      irq_pend  <= (irq_pend & ~irq_clr) | det;
    end
  end

  assign irq = irq_pend & cfg_irq_en;

endmodule

// File: rtl/hall_pos_detect_chk.sv
module hall_pos_detect_chk #(
  parameter int NSENSE = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_cmp_mode,
  input logic [NSENSE-1:0] cfg_in_en,
  input logic [1:0]        cfg_edge_sel,
  input logic [NSENSE-1:0] cfg_expect,
  input logic              cfg_irq_en,
  input logic [NSENSE-1:0] sense_in,
  input logic              irq_clr,
  input logic              wr_pulse,
  input logic              irq_pend,
  input logic              irq
);

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !cfg_irq_en |-> !irq);

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> irq_pend);

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_pend && !irq_clr) |=> irq_pend);

  p_pulse_sets_flag_r8: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |-> irq_pend);

  p_reset_quiet_r10: assert property (@(posedge clk)
    $past(rst) |-> (!wr_pulse && !irq_pend));

  p_none_sel_r3: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |-> !($past(cfg_cmp_mode) == 1'b0 && $past(cfg_edge_sel) == 2'b00));

  p_no_enable_r4: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |-> ($past(cfg_cmp_mode) || $past(cfg_in_en) != '0));

  p_cmp_match_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_pulse && cfg_cmp_mode && $past(cfg_cmp_mode) && $past(cfg_cmp_mode, 2))
      |-> ($past(sense_in, 2) == $past(cfg_expect)));

endmodule

bind hall_pos_detect hall_pos_detect_chk #(.NSENSE(NSENSE)) chk_i (
  .clk(clk), .rst(rst), .cfg_cmp_mode(cfg_cmp_mode), .cfg_in_en(cfg_in_en),
  .cfg_edge_sel(cfg_edge_sel), .cfg_expect(cfg_expect), .cfg_irq_en(cfg_irq_en),
  .sense_in(sense_in), .irq_clr(irq_clr), .wr_pulse(wr_pulse),
  .irq_pend(irq_pend), .irq(irq)
);

// File: tb/hall_pos_detect_tb_top.sv
`timescale 1ns/1ps
module hall_pos_detect_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_cmp_mode = 1'b0;
  logic [2:0] cfg_in_en = 3'b111;
  logic [1:0] cfg_edge_sel = 2'b11;
  logic [2:0] cfg_expect = 3'b000;
  logic cfg_irq_en = 1'b1;
  logic [2:0] sense_in = 3'b111;
  logic irq_clr = 1'b0;
  logic wr_pulse, irq_pend, irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hall_pos_detect dut_i (
    .clk(clk), .rst(rst), .cfg_cmp_mode(cfg_cmp_mode), .cfg_in_en(cfg_in_en),
    .cfg_edge_sel(cfg_edge_sel), .cfg_expect(cfg_expect), .cfg_irq_en(cfg_irq_en),
    .sense_in(sense_in), .irq_clr(irq_clr), .wr_pulse(wr_pulse),
    .irq_pend(irq_pend), .irq(irq)
  );

  // {cmp, en[2:0], sel[1:0], expect[2:0], in[2:0], pulse}
  localparam int NV = 19;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 3'b111, 2'b10, 3'b000, 3'b001, 1'b1},
    {1'b0, 3'b111, 2'b10, 3'b000, 3'b000, 1'b0},
    {1'b0, 3'b111, 2'b01, 3'b000, 3'b010, 1'b0},
    {1'b0, 3'b111, 2'b01, 3'b000, 3'b000, 1'b1},
    {1'b0, 3'b111, 2'b11, 3'b000, 3'b100, 1'b1},
    {1'b0, 3'b111, 2'b11, 3'b000, 3'b000, 1'b1},
    {1'b0, 3'b111, 2'b00, 3'b000, 3'b111, 1'b0},
    {1'b0, 3'b111, 2'b00, 3'b000, 3'b000, 1'b0},
    {1'b0, 3'b001, 2'b11, 3'b000, 3'b010, 1'b0},
    {1'b0, 3'b001, 2'b11, 3'b000, 3'b110, 1'b0},
    {1'b0, 3'b001, 2'b11, 3'b000, 3'b111, 1'b1},
    {1'b0, 3'b001, 2'b11, 3'b000, 3'b110, 1'b1},
    {1'b1, 3'b000, 2'b00, 3'b101, 3'b100, 1'b0},
    {1'b1, 3'b000, 2'b00, 3'b101, 3'b101, 1'b1},
    {1'b1, 3'b000, 2'b00, 3'b101, 3'b101, 1'b0},
    {1'b1, 3'b000, 2'b00, 3'b011, 3'b111, 1'b0},
    {1'b1, 3'b000, 2'b00, 3'b011, 3'b011, 1'b1},
    {1'b1, 3'b000, 2'b00, 3'b000, 3'b000, 1'b1},
    {1'b0, 3'b111, 2'b11, 3'b000, 3'b111, 1'b1}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int i);
    if (i < 2)       return "R1";
    else if (i < 6)  return "R2";
    else if (i < 8)  return "R3";
    else if (i < 12) return "R4";
    else if (i < 14) return "R5";
    else if (i < 16) return "R6";
    else             return "R7";
  endfunction

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cycles(3);
    chk("R10 reset pulse", wr_pulse, 1'b0);
    chk("R10 reset flag", irq_pend, 1'b0);
    chk("R10 reset irq", irq, 1'b0);
    rst = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R10 no pulse after release with inputs high", wr_pulse, 1'b0);
    end
    chk("R10 flag quiet after release", irq_pend, 1'b0);

    // R11 latency and R7 width: falling edges on all three inputs at once
    sense_in = 3'b000;
    @(negedge clk);
    chk("R11 no pulse one edge after sample", wr_pulse, 1'b0);
    @(negedge clk);
    chk("R11 pulse two edges after sample", wr_pulse, 1'b1);
    @(negedge clk);
    chk("R7 pulse width one cycle", wr_pulse, 1'b0);
    chk("R8 flag set by detection", irq_pend, 1'b1);
    cycles(3);
    chk("R8 flag held without clear", irq_pend, 1'b1);
    cfg_irq_en = 1'b0;
    #0.5;
    chk("R9 irq masked", irq, 1'b0);
    cfg_irq_en = 1'b1;
    #0.5;
    chk("R9 irq shown", irq, 1'b1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R8 flag cleared", irq_pend, 1'b0);
    chk("R9 irq low after clear", irq, 1'b0);

    for (int i = 0; i < NV; i++) begin
      cfg_cmp_mode = VEC[i][12];
      cfg_in_en    = VEC[i][11:9];
      cfg_edge_sel = VEC[i][8:7];
      cfg_expect   = VEC[i][6:4];
      sense_in     = VEC[i][3:1];
      cycles(2);
      chk($sformatf("%s table step %0d", tag_of(i), i), wr_pulse, VEC[i][0]);
    end

    // R8 clear and detection in the same cycle
    cfg_cmp_mode = 1'b0; cfg_in_en = 3'b111; cfg_edge_sel = 2'b11;
    cycles(2);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R8 flag cleared before collision", irq_pend, 1'b0);
    sense_in = 3'b000;
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R8 collision pulse", wr_pulse, 1'b1);
    chk("R8 flag survives clear with detection", irq_pend, 1'b1);

    // R10 reset mid-run clears flag
    rst = 1'b1;
    @(negedge clk);
    chk("R10 reset clears flag", irq_pend, 1'b0);
    rst = 1'b0;
    cycles(3);
    chk("R10 no pulse after second reset", wr_pulse, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule